// File: doc/BRIEF.md
# Byte-Banked Digital I/O Register File

This block sits on a narrow byte-wide register bus and serves a 56-line digital I/O port. Twenty-four lines are dedicated outputs that drive external switches. Twenty-four lines are dedicated inputs from isolated receivers. The last eight lines form one shared logic-level port, and a control bit decides whether that port drives or listens. Software moves data through sixteen byte registers at consecutive offsets. It writes output latches, reads back what it wrote, and reads the input pins after they have been brought into the clock domain by a synchroniser.

Change-of-state detection and the interrupt source live in a neighbouring block. This block keeps only the enable byte that the neighbour uses and a status view of the interrupt line's level. The four change-of-state status slots read as zero here. Writing any value to the top register clears every latch, the control byte and the change-of-state enables in a single clock edge, just as the reset input does.

Top module: `dio_bank`

## Requirements
- R1: While `rst` is high and on the first edge after it is released, `sw_out`, `lvl_out`, `lvl_oe` and `rd_data` are all zero. The logic-level port comes out of reset in input mode.
- R2: A write to offset 0x0, 0x1 or 0x2 stores the byte in switch-output lines 0-7, 8-15 or 16-23 respectively. The new value is on `sw_out` from the clock edge that takes the write. A later read of the same offset returns it.
- R3: Offset 0x3 is the logic-level output latch. It is read/write, and a read returns the last value written whatever the port's direction.
- R4: Bit 1 of the control byte at offset 0xC sets the port direction. When it is 1, `lvl_oe` is all ones and `lvl_out` equals the output latch. When it is 0, `lvl_oe` and `lvl_out` are all zeros, and latch writes do not reach the pins. All eight control bits read back as written.
- R5: Offsets 0x4, 0x5 and 0x6 are read-only and return isolated input lines 0-7, 8-15 and 16-23. A pin change first shows in a read whose address is presented at the third clock edge after the change. Reads at the first two edges still show the previous value.
- R6: Offset 0x7 is read-only. In input mode it returns the synchronised logic-level pins. In output mode it returns the output latch.
- R7: Offsets 0x8-0xB (change-of-state status) and 0xD (reserved) read as zero. Writes to them change no register and no pin.
- R8: Offset 0xE holds the change-of-state enable byte. It is read/write.
- R9: A write of any data to offset 0xF clears, on that clock edge, the switch-output latches, the logic-level latch, the control byte (which returns the port to input mode) and the change-of-state enable byte.
- R10: A read of offset 0xF returns the synchronised level of `irq_pin` in bit 0, with bits 7:1 zero.
- R11: `rd_data` is registered. It shows, one edge after the address is presented, the register contents from before any write taken on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| sw_out | output | 24 | Switch output lines |
| iso_in | input | 24 | Isolated input lines (asynchronous) |
| lvl_out | output | 8 | Logic-level port drive value |
| lvl_oe | output | 8 | Logic-level port drive enable |
| lvl_in | input | 8 | Logic-level port pin levels (asynchronous) |
| irq_pin | input | 1 | Level of the interrupt line, for status reads |

## Verification
Two things can happen on the same edge: a register is written, and the same address is read back. The bench provokes this on every write, because each bus operation presents its address and write strobe together. The model computes the expected read byte from its state before the write is applied, so an update that leaks into the same cycle's read data is caught. The software-reset write is the sharpest case. Its read returns the status byte, and from that edge every latch and the port direction must already be clear, which the bench checks on the pins in the following half cycle.

// File: rtl/dio_pkg.sv
package dio_pkg;
  localparam int BYTE_W    = 8;
  localparam int OUT_BYTES = 3;
  localparam int IN_BYTES  = 3;
  localparam int ADDR_W    = 4;
  localparam int OUT_W     = OUT_BYTES * BYTE_W;
  localparam int IN_W      = IN_BYTES * BYTE_W;

  // Offsets: the order matters to software, so it is fixed here.
  localparam logic [ADDR_W-1:0] A_OUT0    = 4'h0;
  localparam logic [ADDR_W-1:0] A_LVL_LAT = 4'h3;
  localparam logic [ADDR_W-1:0] A_IN0     = 4'h4;
  localparam logic [ADDR_W-1:0] A_LVL_IN  = 4'h7;
  localparam logic [ADDR_W-1:0] A_CTRL    = 4'hC;
  localparam logic [ADDR_W-1:0] A_RSVD    = 4'hD;
  localparam logic [ADDR_W-1:0] A_COS_EN  = 4'hE;
  localparam logic [ADDR_W-1:0] A_SRST    = 4'hF;

  localparam int MODE_BIT = 1;

  typedef struct packed {
    logic [OUT_W-1:0]  outs;
    logic [BYTE_W-1:0] lvl;
    logic [BYTE_W-1:0] ctrl;
    logic [BYTE_W-1:0] cos_en;
  } dio_regs_t;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dio_regs.sv
module dio_regs
  import dio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output dio_regs_t         regs
);
  logic clr;
  assign clr = rst | (wr_en && addr == A_SRST);

  generate
    for (genvar b = 0; b < OUT_BYTES; b++) begin : g_out
      localparam logic [ADDR_W-1:0] MY_ADDR = A_OUT0 + ADDR_W'(b);
      always_ff @(posedge clk) begin
        if (clr) regs.outs[b*BYTE_W +: BYTE_W] <= '0;
        else if (wr_en && addr == MY_ADDR) regs.outs[b*BYTE_W +: BYTE_W] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (clr) begin
      regs.lvl    <= '0;
      regs.ctrl   <= '0;
      regs.cos_en <= '0;
    end else if (wr_en) begin
      if (addr == A_LVL_LAT) regs.lvl    <= wr_data;
      if (addr == A_CTRL)    regs.ctrl   <= wr_data;
      if (addr == A_COS_EN)  regs.cos_en <= wr_data;
    end
  end
endmodule

// File: rtl/dio_rdmux.sv
module dio_rdmux
  import dio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  dio_regs_t         regs,
  input  logic [IN_W-1:0]   iso_s,
  input  logic [BYTE_W-1:0] lvl_s,
  input  logic              irq_s,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] sel;
  logic              out_mode;
  assign out_mode = regs.ctrl[MODE_BIT];

  always_comb begin
    sel = '0;
    if (addr < A_LVL_LAT) begin
      for (int b = 0; b < OUT_BYTES; b++)
        if (addr == A_OUT0 + ADDR_W'(b)) sel = regs.outs[b*BYTE_W +: BYTE_W];
    end else if (addr == A_LVL_LAT) begin
      sel = regs.lvl;
    end else if (addr < A_LVL_IN) begin
      for (int b = 0; b < IN_BYTES; b++)
        if (addr == A_IN0 + ADDR_W'(b)) sel = iso_s[b*BYTE_W +: BYTE_W];
    end else begin
      case (addr)
        A_LVL_IN: sel = out_mode ? regs.lvl : lvl_s;
        A_CTRL:   sel = regs.ctrl;
        A_COS_EN: sel = regs.cos_en;
        A_SRST:   sel = {{(BYTE_W-1){1'b0}}, irq_s};
        default:  sel = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= sel;
  end
endmodule

// File: rtl/dio_bank.sv
module dio_bank
  import dio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic [OUT_W-1:0]  sw_out,
  input  logic [IN_W-1:0]   iso_in,
  output logic [BYTE_W-1:0] lvl_out,
  output logic [BYTE_W-1:0] lvl_oe,
  input  logic [BYTE_W-1:0] lvl_in,
  input  logic              irq_pin
);
  localparam int SYNC_W = IN_W + BYTE_W + 1;

  dio_regs_t         regs;
  logic [SYNC_W-1:0] sync_q;
  logic [IN_W-1:0]   iso_s;
  logic [BYTE_W-1:0] lvl_s;
  logic              irq_s;

  dio_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({irq_pin, lvl_in, iso_in}),
    .q   (sync_q)
  );
  assign {irq_s, lvl_s, iso_s} = sync_q;

  dio_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .regs    (regs)
  );

  dio_rdmux u_rd (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .regs    (regs),
    .iso_s   (iso_s),
    .lvl_s   (lvl_s),
    .irq_s   (irq_s),
    .rd_data (rd_data)
  );

  assign sw_out  = regs.outs;
  assign lvl_oe  = {BYTE_W{regs.ctrl[MODE_BIT]}};
  assign lvl_out = regs.ctrl[MODE_BIT] ? regs.lvl : '0;
endmodule

// File: rtl/dio_bank_chk.sv
module dio_bank_chk
  import dio_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [BYTE_W-1:0] wr_data,
  input logic [BYTE_W-1:0] rd_data,
  input logic [OUT_W-1:0]  sw_out,
  input logic [BYTE_W-1:0] lvl_out,
  input logic [BYTE_W-1:0] lvl_oe
);
  p_out_byte0_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 4'h0) |=> sw_out[7:0] == $past(wr_data));

  p_sw_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (addr <= 4'h2 || addr == 4'hF)) |=> $stable(sw_out));

  p_oe_mode_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 4'hC) |=> lvl_oe == {BYTE_W{$past(wr_data[1])}});

  p_no_drive_r4: assert property (@(posedge clk) disable iff (rst)
    (lvl_oe == '0) |-> (lvl_out == '0));

  p_zero_slots_r7: assert property (@(posedge clk) disable iff (rst)
    (addr == 4'hD || (addr >= 4'h8 && addr <= 4'hB)) |=> rd_data == '0);

  p_srst_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 4'hF) |=> (sw_out == '0 && lvl_oe == '0 && lvl_out == '0));

  p_status_bits_r10: assert property (@(posedge clk) disable iff (rst)
    (addr == 4'hF) |=> rd_data[7:1] == '0);
endmodule

bind dio_bank dio_bank_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (addr),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .sw_out  (sw_out),
  .lvl_out (lvl_out),
  .lvl_oe  (lvl_oe)
);

// File: tb/sim_dio_bank.sv
`timescale 1ns/1ps
module sim_dio_bank;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  addr;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;
  logic [23:0] sw_out;
  logic [23:0] iso_in;
  logic [7:0]  lvl_out;
  logic [7:0]  lvl_oe;
  logic [7:0]  lvl_in;
  logic        irq_pin;

  int n_checks = 0;
  int n_fail   = 0;

  // model state
  logic [23:0] m_out;
  logic [7:0]  m_lvl, m_ctrl, m_cosen;

  always #5 clk = ~clk;

  dio_bank u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sw_out(sw_out), .iso_in(iso_in), .lvl_out(lvl_out),
    .lvl_oe(lvl_oe), .lvl_in(lvl_in), .irq_pin(irq_pin)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    case (a)
      4'h0, 4'h1, 4'h2: return m_out[a*8 +: 8];
      4'h3: return m_lvl;
      4'h4, 4'h5, 4'h6: return iso_in[(a-4)*8 +: 8];
      4'h7: return m_ctrl[1] ? m_lvl : lvl_in;
      4'hC: return m_ctrl;
      4'hE: return m_cosen;
      4'hF: return {7'b0, irq_pin};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] a);
    case (a)
      4'h0, 4'h1, 4'h2: return "R2/R11";
      4'h3: return "R3/R11";
      4'h4, 4'h5, 4'h6: return "R5/R11";
      4'h7: return "R6/R11";
      4'hC: return "R4/R11";
      4'hE: return "R8/R11";
      4'hF: return "R10/R11";
      default: return "R7/R11";
    endcase
  endfunction

  task automatic check_pins(input string req);
    check({req, " sw_out"}, 32'(sw_out), 32'(m_out));
    check({req, " lvl_oe"}, 32'(lvl_oe), m_ctrl[1] ? 32'hFF : 32'h0);
    check({req, " lvl_out"}, 32'(lvl_out), m_ctrl[1] ? 32'(m_lvl) : 32'h0);
  endtask

  // one bus cycle; starts and ends at a falling edge
  task automatic op(input logic [3:0] a, input logic we, input logic [7:0] d,
                    input logic do_rd_check);
    logic [7:0] e;
    e = exp_read(a);
    addr = a; wr_en = we; wr_data = d;
    @(posedge clk);
    if (we) begin
      case (a)
        4'h0, 4'h1, 4'h2: m_out[a*8 +: 8] = d;
        4'h3: m_lvl = d;
        4'hC: m_ctrl = d;
        4'hE: m_cosen = d;
        4'hF: begin m_out = '0; m_lvl = '0; m_ctrl = '0; m_cosen = '0; end
        default: ;
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0;
    if (do_rd_check) check(req_of(a), 32'(rd_data), 32'(e));
  endtask

  task automatic settle();
    for (int i = 0; i < 3; i++) op(4'hD, 1'b0, 8'h00, 1'b0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    rst = 1'b1; addr = '0; wr_en = 1'b0; wr_data = '0;
    iso_in = 24'h0; lvl_in = 8'h0; irq_pin = 1'b0;
    m_out = '0; m_lvl = '0; m_ctrl = '0; m_cosen = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 rd_data", 32'(rd_data), 32'h0);
    check_pins("R1");
    rst = 1'b0;
    @(negedge clk);
    check_pins("R1");

    // R2 output bytes
    op(4'h0, 1'b1, 8'h5A, 1'b1); check_pins("R2");
    op(4'h2, 1'b1, 8'hC3, 1'b1); check_pins("R2");
    op(4'h0, 1'b0, 8'h00, 1'b1);
    op(4'h2, 1'b0, 8'h00, 1'b1);
    // R11 same-cycle write and read returns old value
    op(4'h1, 1'b1, 8'h11, 1'b1);
    op(4'h1, 1'b1, 8'h22, 1'b1);

    // R4/R3: latch write in input mode does not reach pins
    op(4'h3, 1'b1, 8'hA5, 1'b1); check_pins("R4");
    op(4'h3, 1'b0, 8'h00, 1'b1);
    // R6 input mode reads pins
    lvl_in = 8'h3C; settle();
    op(4'h7, 1'b0, 8'h00, 1'b1);
    // R4 output mode
    op(4'hC, 1'b1, 8'h82, 1'b1); check_pins("R4");
    op(4'hC, 1'b0, 8'h00, 1'b1);
    op(4'h7, 1'b0, 8'h00, 1'b1); // R6 output mode: latch
    op(4'h3, 1'b0, 8'h00, 1'b1); // R3

    // R7 ignored writes
    op(4'h8, 1'b1, 8'hFF, 1'b1); check_pins("R7");
    op(4'h8, 1'b0, 8'h00, 1'b1);
    op(4'hD, 1'b1, 8'hFF, 1'b1);
    op(4'hD, 1'b0, 8'h00, 1'b1);
    // R8 change-of-state enable
    op(4'hE, 1'b1, 8'h77, 1'b1);
    op(4'hE, 1'b0, 8'h00, 1'b1);

    // R5 synchroniser latency: new value only on the third edge
    begin
      logic [7:0] old_v;
      old_v = iso_in[15:8];
      iso_in = 24'h00_9600;
      addr = 4'h5; wr_en = 1'b0;
      @(posedge clk); @(negedge clk);
      check("R5 edge1", 32'(rd_data), 32'(old_v));
      @(posedge clk); @(negedge clk);
      check("R5 edge2", 32'(rd_data), 32'(old_v));
      @(posedge clk); @(negedge clk);
      check("R5 edge3", 32'(rd_data), 32'h96);
    end

    // R10 interrupt level
    irq_pin = 1'b1; settle();
    op(4'hF, 1'b0, 8'h00, 1'b1);
    irq_pin = 1'b0; settle();
    op(4'hF, 1'b0, 8'h00, 1'b1);

    // R9 software reset with any data value
    op(4'hF, 1'b1, 8'h00, 1'b1); check_pins("R9");
    op(4'hC, 1'b0, 8'h00, 1'b1);
    op(4'hE, 1'b0, 8'h00, 1'b1);
    op(4'h3, 1'b0, 8'h00, 1'b1);
    op(4'h0, 1'b0, 8'h00, 1'b1);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] a;
      logic       we;
      if (($urandom() % 16) == 0) begin
        iso_in  = 24'($urandom());
        lvl_in  = 8'($urandom());
        irq_pin = 1'($urandom());
        settle();
      end
      a  = 4'($urandom_range(0, 15));
      we = 1'($urandom());
      if (a == 4'hF && ($urandom() % 4) != 0) we = 1'b0;
      op(a, we, 8'($urandom()), 1'b1);
      check_pins(we && a == 4'hF ? "R9" : (a == 4'hC ? "R4" : "R2"));
    end

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule